// File: doc/BRIEF.md
# Serial Result Port with Word Sync and Tag Chaining

This block is the digital output side of a 16-bit sampling converter. A finished conversion result arrives as a parallel word on a valid/ready interface. The block holds it and sends it out MSB first on one serial data line, timed by a free-running external data clock. A one-clock sync pulse comes before each word. Once the LSB is out, the line carries the tag input, delayed by exactly one word length. Several ports can then share one data line in a daisy chain: each device's tag input takes the data output of the device upstream.

A read sequence has to be armed first. Arming happens on any data-clock edge that is not a read edge: chip select high, or chip select low with the read/convert line low. The next read edge (chip select low, read/convert high, busy high) is pulse 1 and launches the sync pulse. Result bits and then tag bits follow, one per edge. The result handshake is open only while a conversion is pending. `res_ready` is high exactly while busy is low. The source keeps `res_valid` and `res_data` steady until it sees ready. Only one word is taken per conversion, and a valid presented while ready is low has no effect. Everything is synchronous to the rising edge of the data clock.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, `data_out`=0, `sync_out`=0, `busy_n`=1 and `res_ready`=0.
- R2: A conversion starts when `rd_cn` is 1 on one edge and 0 on the next edge, with `cs_n`=0 and `busy_n`=1. After that edge `busy_n`=0 and `res_ready`=1.
- R3: On an edge where `res_valid` and `res_ready` are both 1, `res_data` is stored and `busy_n` returns to 1. A `res_valid` presented while `res_ready`=0 leaves the stored word unchanged.
- R4: An edge with `cs_n`=1, or with `cs_n`=0 and `rd_cn`=0, arms the port. The read condition is `cs_n`=0 and `rd_cn`=1.
- R5: The first read-condition edge with `busy_n`=1 after arming is pulse 1. After pulse 1, `sync_out`=1 for exactly one clock.
- R6: After pulse p, for p from 2 to 17, `data_out` equals stored bit 17-p. Bit 15 comes after pulse 2 and bit 0 after pulse 17.
- R7: After pulse p, for p of 18 or more, `data_out` equals the `tag_in` level sampled on pulse p-16. This continues for as long as the read condition holds.
- R8: An edge where the read condition is false during a word aborts it, and afterwards `data_out`=0 and `sync_out`=0. That edge also arms the port, so the next read restarts at pulse 1.
- R9: Read-condition edges with `busy_n`=0 do not launch a word. The port stays armed and launches on the first read edge after `busy_n` returns to 1. Holding the read condition after a word does not cause a second sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External continuous data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_cn | input | 1 | Read (1) / convert (0) |
| tag_in | input | 1 | Chained serial input from upstream device |
| res_valid | input | 1 | Conversion result valid |
| res_data | input | 16 | Conversion result word |
| res_ready | output | 1 | Result accepted on this edge when valid |
| data_out | output | 1 | Serial data line |
| sync_out | output | 1 | Word-start pulse |
| busy_n | output | 1 | Low while a conversion is pending |

## Verification
Every output is registered once on the data clock, so each result is due one edge after the inputs that cause it. `busy_n` and `res_ready` change one edge after a start or a handshake. Sync shows after pulse 1 and result bit 17-p after pulse p. The tag level driven on pulse p comes back after pulse p+16. The bench drives inputs on the falling edge and samples on the following falling edge, so each sample covers exactly one rising edge. It keeps a per-pulse record of the tag levels it drove and computes each expected value from the pulse number.

// File: rtl/conv_port_pkg.sv
package conv_port_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/cport_conv_ctrl.sv
module cport_conv_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_cn,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  output logic         res_ready,
  output logic         busy_n,
  output logic [W-1:0] word_q
);
  logic rd_q;
  logic start;

  assign start     = !cs_n && !rd_cn && rd_q && busy_n;
  assign res_ready = !busy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      busy_n <= 1'b1;
      word_q <= '0;
    end else begin
      rd_q <= rd_cn;
      if (start) begin
        busy_n <= 1'b0;
      end else if (!busy_n && res_valid) begin
        word_q <= res_data;
        busy_n <= 1'b1;
      end
    end
  end

  p_busy_fall_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(!cs_n) && $past(!rd_cn)));

  p_handshake_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> busy_n);
endmodule

// File: rtl/cport_tag_delay.sv
module cport_tag_delay #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_in,
  output logic tag_out
);
  logic [DEPTH-1:0] stage;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) stage[i] <= 1'b0;
        else        stage[i] <= tag_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) stage[i] <= 1'b0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign tag_out = stage[DEPTH-1];
endmodule

// File: rtl/cport_serializer.sv
module cport_serializer
  import conv_port_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_cn,
  input  logic         busy_n,
  input  logic [W-1:0] word,
  input  logic         tag_dly,
  output logic         data_out,
  output logic         sync_out
);
  localparam int CW   = $clog2(W + 2);
  localparam int IW   = $clog2(W);
  localparam int LAST = W + 1;

  seq_state_e    state;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic          read_cond;

  assign read_cond = !cs_n && rd_cn;
  assign idx       = CW'(W) - cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      armed    <= 1'b0;
      cnt      <= '0;
      data_out <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          data_out <= 1'b0;
          sync_out <= 1'b0;
          if (!read_cond) begin
            armed <= 1'b1;
          end else if (busy_n && armed) begin
            state    <= SEQ_RUN;
            armed    <= 1'b0;
            cnt      <= CW'(1);
            sync_out <= 1'b1;
          end
        end
        default: begin
          sync_out <= 1'b0;
          if (!read_cond) begin
            state    <= SEQ_IDLE;
            armed    <= 1'b1;
            cnt      <= '0;
            data_out <= 1'b0;
          end else if (cnt < CW'(LAST)) begin
            data_out <= word[idx[IW-1:0]];
            cnt      <= cnt + CW'(1);
          end else begin
            data_out <= tag_dly;
          end
        end
      endcase
    end
  end

  p_sync_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);

  p_abort_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!data_out && !sync_out));

  p_sync_needs_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> busy_n);
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_cn,
  input  logic         tag_in,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  output logic         res_ready,
  output logic         data_out,
  output logic         sync_out,
  output logic         busy_n
);
  logic [W-1:0] word_q;
  logic         tag_dly;

  cport_conv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cn(rd_cn),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .busy_n(busy_n), .word_q(word_q)
  );

  cport_tag_delay #(.DEPTH(W)) u_tag (
    .clk(clk), .rst_n(rst_n), .tag_in(tag_in), .tag_out(tag_dly)
  );

  cport_serializer #(.W(W)) u_ser (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cn(rd_cn), .busy_n(busy_n),
    .word(word_q), .tag_dly(tag_dly), .data_out(data_out), .sync_out(sync_out)
  );
endmodule

// File: tb/conv_serial_port_test.sv
module conv_serial_port_test;
  localparam int W = 16;
  localparam int LASTP = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_cn = 1'b1, tag_in = 1'b0, res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic res_ready, data_out, sync_out, busy_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic tagv [0:63];

  always #2.5 clk = ~clk;

  conv_serial_port #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cn(rd_cn), .tag_in(tag_in),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .data_out(data_out), .sync_out(sync_out), .busy_n(busy_n)
  );

  function automatic logic exp_data(logic [W-1:0] r, int p);
    if (p >= 2 && p <= W + 1) return r[W + 1 - p];
    return tagv[p - W];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic convert(logic [W-1:0] r);
    cs_n = 1'b0; rd_cn = 1'b1; step();
    rd_cn = 1'b0; step();
    check(busy_n == 1'b0, "R2 busy", int'(busy_n), 0);
    check(res_ready == 1'b1, "R2 ready", int'(res_ready), 1);
    res_valid = 1'b1; res_data = r; step();
    res_valid = 1'b0;
    check(busy_n == 1'b1, "R3 busy back", int'(busy_n), 1);
    check(res_ready == 1'b0, "R3 ready low", int'(res_ready), 0);
  endtask

  task automatic read_word(logic [W-1:0] r, logic [W-1:0] up, int stop_at);
    cs_n = 1'b1; rd_cn = 1'b1; step();
    cs_n = 1'b0;
    for (int p = 1; p <= stop_at; p++) begin
      if (p >= 2 && p <= W + 1) tagv[p] = up[W + 1 - p];
      else tagv[p] = 1'(($urandom() >> 3) & 1);
      tag_in = tagv[p];
      step();
      if (p == 1) begin
        check(sync_out == 1'b1, "R5 sync", int'(sync_out), 1);
      end else begin
        check(sync_out == 1'b0, "R5 sync single", int'(sync_out), 0);
        if (p <= W + 1)
          check(data_out == exp_data(r, p), "R6 bit", int'(data_out), int'(exp_data(r, p)));
        else
          check(data_out == exp_data(r, p), "R7 tag", int'(data_out), int'(exp_data(r, p)));
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] r;
    logic [W-1:0] up;
    void'($urandom(32'd1234));
    @(negedge clk);
    step(); step();
    check(data_out == 1'b0, "R1 data", int'(data_out), 0);
    check(sync_out == 1'b0, "R1 sync", int'(sync_out), 0);
    check(busy_n == 1'b1, "R1 busy", int'(busy_n), 1);
    check(res_ready == 1'b0, "R1 ready", int'(res_ready), 0);
    rst_n = 1'b1; step();

    for (int i = 0; i < 20; i++) begin
      r  = W'($urandom());
      up = W'($urandom());
      if (i == 0) begin r = 16'hFFFF; up = 16'h0000; end
      if (i == 1) begin r = 16'h0001; up = 16'h8001; end
      convert(r);
      read_word(r, up, LASTP);
      cs_n = 1'b1; step();
      check(data_out == 1'b0 && sync_out == 1'b0, "R4 idle after cs", int'(data_out), 0);
    end

    // R3: valid while not ready is ignored
    r = 16'hA5C3;
    convert(r);
    res_valid = 1'b1; res_data = 16'h1111; cs_n = 1'b1; step();
    check(busy_n == 1'b1, "R3 ignored valid busy", int'(busy_n), 1);
    res_valid = 1'b0;
    read_word(r, 16'h0F0F, W + 2);

    // R8: abort mid-word, then restart
    r = 16'h3C5A;
    convert(r);
    read_word(r, 16'h1234, 8);
    cs_n = 1'b1; step();
    check(data_out == 1'b0, "R8 abort data", int'(data_out), 0);
    check(sync_out == 1'b0, "R8 abort sync", int'(sync_out), 0);
    read_word(r, 16'h4321, LASTP);

    // R9: reads while busy do not launch; launch after result arrives
    cs_n = 1'b1; step();
    r = 16'h9E37;
    cs_n = 1'b0; rd_cn = 1'b1; step();
    rd_cn = 1'b0; step();
    check(busy_n == 1'b0, "R2 busy", int'(busy_n), 0);
    rd_cn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check(sync_out == 1'b0, "R9 no launch while busy", int'(sync_out), 0);
    end
    res_valid = 1'b1; res_data = r; step();
    res_valid = 1'b0;
    check(sync_out == 1'b0, "R9 no launch on accept edge", int'(sync_out), 0);
    step();
    check(sync_out == 1'b1, "R9 launch after busy high", int'(sync_out), 1);
    for (int p = 2; p <= W + 1; p++) begin
      step();
      check(data_out == exp_data(r, p), "R9 bit", int'(data_out), int'(exp_data(r, p)));
    end
    for (int k = 0; k < 30; k++) begin
      step();
      check(sync_out == 1'b0, "R9 no second sync", int'(sync_out), 0);
    end
    cs_n = 1'b1; step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule